// File: doc/BRIEF.md
# Population and Leading-Zero Counter

This block counts bits in a 64-bit operand and returns a 7-bit count. A one-bit function select picks one of two counts. The first is the number of ones anywhere in the operand. The second is the number of zero bits that sit above the highest set bit. Each function has its own pipeline, and the two depths differ: the ones count takes four cycles and the leading-zero count takes three. A single result port carries the count, a valid flag and a tag that names the operation that produced it.

An operand is taken in any cycle where `in_valid` and `in_ready` are both high. The block lowers `in_ready` for one case only. In the cycle right after a ones-count operand is accepted, a leading-zero request would finish in the same cycle as that ones count. The block refuses that request so that the two never meet at the output. Ones-count requests are never refused.

Top module: `pzc_unit`

## Requirements
- R1: With `in_op` = 0 (ones count), the result equals the number of one bits in the accepted operand, from 0 to 64.
- R2: With `in_op` = 1 (leading-zero count), the result equals the number of zero bits above the most significant one bit of the accepted operand.
- R3: A leading-zero count of an all-zero operand returns 64.
- R4: A ones-count operand presented and accepted in cycle c has its result on the outputs in cycle c+4.
- R5: A leading-zero operand presented and accepted in cycle c has its result on the outputs in cycle c+3.
- R6: In the cycle after a ones-count operand is accepted, `in_ready` is low while `in_op` = 1. In every other case `in_ready` is high, and this includes back-to-back ones-count requests.
- R7: `out_op` carries the operation of the result it goes with (0 ones count, 1 leading-zero count). Each cycle presents at most one result.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: An operand that is not accepted produces no result. This covers an operand with `in_valid` low and one refused because `in_ready` is low.
- R10: Both pipelines take a new operand every cycle and deliver one result per cycle when fed continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_op | input | 1 | Function: 0 ones count, 1 leading-zero count |
| in_data | input | 64 | Operand |
| in_ready | output | 1 | Operand can be taken this cycle |
| out_valid | output | 1 | Result present |
| out_op | output | 1 | Function that produced the result |
| out_count | output | 7 | Count |

## Verification
The bench builds the block with its default parameters. These are a 64-bit operand, 8-bit leaves in the ones-count adder tree and 8-bit segments in the leading-zero priority tree. With these values every segment boundary is in reach: each of the 64 single-bit operands lands the top one bit in a different segment at a different offset, in both modes. The latency gap between the two pipelines is exactly one cycle with these values. A ones count followed at once by a leading-zero request therefore exercises the refusal path. Mixed random traffic then checks that results keep their order and their tags.

// File: rtl/pzc_pkg.sv
package pzc_pkg;
   typedef enum logic {
      CNT_POP = 1'b0,
      CNT_LZC = 1'b1
   } cnt_op_e;

   localparam int POP_STAGES = 4;
   localparam int LZC_STAGES = 3;
endpackage

// File: rtl/pzc_pop_pipe.sv
module pzc_pop_pipe #(
   parameter int DATA_W = 64,
   parameter int LEAF_W = 8,
   parameter int CNT_W  = $clog2(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_fire,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [CNT_W-1:0]  out_count
);
   localparam int NLEAF   = DATA_W / LEAF_W;
   localparam int NPAIR   = NLEAF / 2;
   localparam int LEAF_CW = $clog2(LEAF_W) + 1;
   localparam int PAIR_CW = LEAF_CW + 1;

   logic [NLEAF-1:0][LEAF_CW-1:0] leaf_d, leaf_q;
   logic [NPAIR-1:0][PAIR_CW-1:0] pair_d, pair_q;
   logic [CNT_W-1:0]              sum_d, sum_q, res_q;
   logic [3:0]                    v_q;

   // stage 1: leaf counts
   always_comb begin
      for (int i = 0; i < NLEAF; i++) begin
         leaf_d[i] = '0;
         for (int b = 0; b < LEAF_W; b++)
            leaf_d[i] = leaf_d[i] + LEAF_CW'(in_data[i*LEAF_W+b]);
      end
   end

   // stage 2: pair sums
   always_comb begin
      for (int j = 0; j < NPAIR; j++)
         pair_d[j] = PAIR_CW'(leaf_q[2*j]) + PAIR_CW'(leaf_q[2*j+1]);
   end

   // stage 3: final sum
   always_comb begin
      sum_d = '0;
      for (int j = 0; j < NPAIR; j++)
         sum_d = sum_d + CNT_W'(pair_q[j]);
   end

   always_ff @(posedge clk) begin
      leaf_q <= leaf_d;
      pair_q <= pair_d;
      sum_q  <= sum_d;
      res_q  <= sum_q;
      if (!rst_n) v_q <= '0;
      else        v_q <= {v_q[2:0], in_fire};
   end

   assign out_valid = v_q[3];
   assign out_count = res_q;
endmodule

// File: rtl/pzc_lzc_pipe.sv
module pzc_lzc_pipe #(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 8,
   parameter int CNT_W  = $clog2(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_fire,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [CNT_W-1:0]  out_count
);
   localparam int NSEG = DATA_W / SEG_W;
   localparam int LZ_W = $clog2(SEG_W);

   function automatic logic [LZ_W-1:0] seg_lz(input logic [SEG_W-1:0] s);
      logic [LZ_W-1:0] n;
      n = '0;
      for (int b = 0; b < SEG_W; b++)
         if (s[b]) n = LZ_W'(SEG_W - 1 - b);
      return n;
   endfunction

   logic [NSEG-1:0]            nz_d, nz_q;
   logic [NSEG-1:0][LZ_W-1:0]  lz_d, lz_q;
   logic [CNT_W-1:0]           pick_d, pick_q, res_q;
   logic [2:0]                 v_q;

   // stage 1: per-segment flag and local count
   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      assign nz_d[g] = |in_data[g*SEG_W +: SEG_W];
      assign lz_d[g] = seg_lz(in_data[g*SEG_W +: SEG_W]);
   end

   // stage 2: highest non-empty segment wins
   always_comb begin
      pick_d = CNT_W'(DATA_W);
      for (int k = 0; k < NSEG; k++)
         if (nz_q[k]) pick_d = CNT_W'((NSEG - 1 - k) * SEG_W) + CNT_W'(lz_q[k]);
   end

   always_ff @(posedge clk) begin
      nz_q   <= nz_d;
      lz_q   <= lz_d;
      pick_q <= pick_d;
      res_q  <= pick_q;
      if (!rst_n) v_q <= '0;
      else        v_q <= {v_q[1:0], in_fire};
   end

   assign out_valid = v_q[2];
   assign out_count = res_q;
endmodule

// File: rtl/pzc_unit.sv
module pzc_unit #(
   parameter int DATA_W = 64,
   parameter int LEAF_W = 8,
   parameter int SEG_W  = 8,
   parameter int CNT_W  = $clog2(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic              out_op,
   output logic [CNT_W-1:0]  out_count
);
   import pzc_pkg::*;

   localparam int GAP = POP_STAGES - LZC_STAGES;

   if (DATA_W % (2 * LEAF_W) != 0) begin : g_bad_leaf
      $error("DATA_W must be a multiple of twice LEAF_W");
   end
   if (DATA_W % SEG_W != 0) begin : g_bad_seg
      $error("DATA_W must be a multiple of SEG_W");
   end
   if (CNT_W < $clog2(DATA_W) + 1) begin : g_bad_cnt
      $error("CNT_W too narrow to hold DATA_W");
   end
   if (GAP < 1) begin : g_bad_gap
      $error("ones-count pipeline must be deeper than leading-zero pipeline");
   end

   logic             fire, pop_fire, lzc_fire;
   logic             pop_out_valid, lzc_out_valid;
   logic [CNT_W-1:0] pop_count, lzc_count;
   logic             pop_hold;

   assign fire     = in_valid && in_ready;
   assign pop_fire = fire && (in_op == CNT_POP);
   assign lzc_fire = fire && (in_op == CNT_LZC);

   // remember ones-count accepts GAP cycles back
   if (GAP == 1) begin : g_gap1
      logic recent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) recent_q <= 1'b0;
         else        recent_q <= pop_fire;
      end
      assign pop_hold = recent_q;
   end else begin : g_gapn
      logic [GAP-1:0] recent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) recent_q <= '0;
         else        recent_q <= {recent_q[GAP-2:0], pop_fire};
      end
      assign pop_hold = recent_q[GAP-1];
   end

   assign in_ready = !(pop_hold && (in_op == CNT_LZC));

   pzc_pop_pipe #(.DATA_W(DATA_W), .LEAF_W(LEAF_W), .CNT_W(CNT_W)) u_pop (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_fire   (pop_fire),
      .in_data   (in_data),
      .out_valid (pop_out_valid),
      .out_count (pop_count)
   );

   pzc_lzc_pipe #(.DATA_W(DATA_W), .SEG_W(SEG_W), .CNT_W(CNT_W)) u_lzc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_fire   (lzc_fire),
      .in_data   (in_data),
      .out_valid (lzc_out_valid),
      .out_count (lzc_count)
   );

   assign out_valid = pop_out_valid | lzc_out_valid;
   assign out_op    = lzc_out_valid ? CNT_LZC : CNT_POP;
   assign out_count = lzc_out_valid ? lzc_count : (pop_out_valid ? pop_count : '0);
endmodule

// File: rtl/pzc_unit_chk.sv
module pzc_unit_chk #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = $clog2(DATA_W) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_op,
   input logic [DATA_W-1:0] in_data,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_op,
   input logic [CNT_W-1:0]  out_count,
   input logic              pop_v,
   input logic              lzc_v
);
   // R7: the two pipelines never present together
   a_r7_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pop_v, lzc_v}));

   // R4
   a_r4_pop_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 1'b0) |-> ##4 (out_valid && out_op == 1'b0));

   // R5
   a_r5_lzc_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 1'b1) |-> ##3 (out_valid && out_op == 1'b1));

   // R1
   a_r1_pop_value: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == 1'b0) |-> (out_count == CNT_W'($countones($past(in_data, 4)))));

   // R3
   a_r3_lzc_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 1'b1 && in_data == '0) |-> ##3 (out_count == CNT_W'(DATA_W)));

   // R6
   a_r6_hold_lzc: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 1'b0) |=> (in_op == 1'b0 || !in_ready));

   // R6: ones-count requests always taken
   a_r6_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (in_op == 1'b0) |-> in_ready);

   // R1/R2 range
   a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count <= CNT_W'(DATA_W)));
endmodule

bind pzc_unit pzc_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_data   (in_data),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_op    (out_op),
   .out_count (out_count),
   .pop_v     (pop_out_valid),
   .lzc_v     (lzc_out_valid)
);

// File: tb/tb_pzc_unit.sv
module tb_pzc_unit;
   localparam int DATA_W = 64;
   localparam int CNT_W  = 7;
   localparam int LIMIT  = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_op = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_ready;
   logic              out_valid;
   logic              out_op;
   logic [CNT_W-1:0]  out_count;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   int q_op[$];
   int q_cnt[$];
   int q_due[$];

   pzc_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
      .out_op(out_op), .out_count(out_count)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int ref_pop(input logic [DATA_W-1:0] d);
      int n = 0;
      for (int i = 0; i < DATA_W; i++) n += int'(d[i]);
      return n;
   endfunction

   function automatic int ref_lzc(input logic [DATA_W-1:0] d);
      for (int i = DATA_W - 1; i >= 0; i--) if (d[i]) return DATA_W - 1 - i;
      return DATA_W;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // present an operand for one cycle; push an expectation if it is taken
   task automatic try_issue(input int op, input logic [DATA_W-1:0] d, output bit took);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op[0];
      in_data  = d;
      #1;
      took = in_ready;
      if (took) begin
         q_op.push_back(op);
         q_cnt.push_back(op == 0 ? ref_pop(d) : ref_lzc(d));
         q_due.push_back(cyc + (op == 0 ? 4 : 3));   // R4 / R5
      end
   endtask

   task automatic issue(input int op, input logic [DATA_W-1:0] d);
      bit took = 1'b0;
      while (!took) try_issue(op, d, took);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = {DATA_W{1'b1}};
         in_op    = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q_op.size() == 0) begin
               check("R9 unexpected result", 1, 0);
            end else begin
               int eop, ecnt, edue;
               eop  = q_op.pop_front();
               ecnt = q_cnt.pop_front();
               edue = q_due.pop_front();
               check(eop == 0 ? "R4 ones latency" : "R5 lz latency", cyc, edue);
               check("R7 op tag", int'(out_op), eop);
               check(eop == 0 ? "R1 ones count" : "R2 lz count", int'(out_count), ecnt);
            end
         end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
            check("R4/R5 missing result", 0, 1);
            void'(q_op.pop_front()); void'(q_cnt.pop_front()); void'(q_due.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      if (cyc >= LIMIT && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit took;
      logic [DATA_W-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R8 out_valid after reset", int'(out_valid), 0);
      check("R8 in_ready after reset", int'(in_ready), 1);

      issue(0, '0);                       // R1 zero
      issue(0, {DATA_W{1'b1}});           // R1 all ones -> 64
      idle(2);
      issue(1, '0);                       // R3 -> 64
      idle(1);
      issue(1, {DATA_W{1'b1}});           // R2 -> 0
      idle(5);

      // R6: lz request right after a ones count is refused, then taken
      try_issue(0, 64'h00F0, took);
      check("R6 ones taken", int'(took), 1);
      try_issue(1, 64'h1, took);
      check("R6 lz refused after ones", int'(took), 0);
      try_issue(1, 64'h1, took);
      check("R6 lz taken on retry", int'(took), 1);
      // R6: ones after ones always taken
      try_issue(0, 64'h3, took);
      check("R6 ones back-to-back", int'(took), 1);
      try_issue(0, 64'h7, took);
      check("R6 ones back-to-back", int'(took), 1);
      idle(6);

      // R9: refused request must not create a result
      try_issue(0, 64'hFF, took);
      try_issue(1, 64'h8000_0000_0000_0000, took);
      check("R9 refused lz", int'(took), 0);
      idle(8);
      check("R9 no stray results", q_op.size(), 0);

      // single-bit operands, both modes, streamed (R10)
      for (int i = 0; i < DATA_W; i++) issue(1, DATA_W'(1) << i);
      for (int i = 0; i < DATA_W; i++) issue(0, DATA_W'(1) << i);
      idle(6);

      // random mixed traffic with gaps
      for (int i = 0; i < 400; i++) begin
         r = {$urandom(), $urandom()};
         if ($urandom_range(0, 3) == 0) r = r & {$urandom(), $urandom()} & {$urandom(), $urandom()};
         if ($urandom_range(0, 4) == 0) r = r >> $urandom_range(0, DATA_W - 1);
         issue(int'($urandom_range(0, 1)), r);
         if ($urandom_range(0, 3) == 0) idle(1);
      end
      idle(8);
      check("R9 queue drained", q_op.size(), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule